// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial Byte Memory

This block keeps the protection state of a serial byte-addressed memory and rules on every write request the serial front end decodes. It holds a write-enable latch, a software arm bit for the hardware protect pin, and a two-bit field that selects how much of the upper address space is locked against writes. From these it produces a readable status byte, a grant for each status-register write and a grant for each memory byte write.

The serial shifter in front of the block turns the bus traffic into one-cycle strobes in the block's clock domain. These strobes mark the chip-select falling edge (transaction start), the chip-select rising edge (transaction end), the set-enable and clear-enable commands, a status write with its data byte, and each memory byte write with its address. The memory array behind the block writes a byte only when the memory grant is high. The nonvolatile bits are held in ordinary registers that take a parameterised value at reset.

Top module: `nvstat_guard`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0: arm bit, 1, 0, 0, range bit high, range bit low, enable latch, 0. Bits 6, 5, 4 and 0 are fixed at 1, 0, 0 and 0, and no status write changes them.
- R2: The enable latch (status bit 1) is 0 after reset. Only the set-enable strobe sets it, one cycle after the strobe. A status write whose data has bit 1 high leaves the latch unchanged.
- R3: The clear-enable strobe clears the latch one cycle later. If set-enable and clear-enable arrive in the same cycle, clear wins.
- R4: The end-of-transaction strobe clears the latch when the transaction carried at least one status-write or memory-write strobe, whether or not that write was granted, and when that strobe falls in the same cycle as the end strobe. A transaction with no write strobe leaves the latch unchanged.
- R5: A status write is granted, in the same cycle as its strobe, only when the latch is 1 and the register is not locked. The register is locked only when the arm bit (status bit 7) is 1 and the sampled pin is 0. A granted write loads status bits 7, 3 and 2 from data bits 7, 3 and 2 one cycle later.
- R6: The active-low protect pin is sampled only on the start-of-transaction strobe. A change of the pin within a transaction has no effect until the next start strobe.
- R7: The range field (status bits 3:2) protects the following addresses: 00 none; 01 the top quarter, where the two address MSBs are 11 (30000h to 3FFFFh with the default 18 bits); 10 the top half, where the address MSB is 1 (20000h to 3FFFFh); 11 every address.
- R8: A memory byte write is granted, in the same cycle as its strobe, only when the latch is 1 and its address lies outside the protected range. The protect pin and the arm bit never affect it.
- R9: After reset the arm bit and range field take the value of parameter NV_RST_VAL (default 0), so the status byte reads 40h.
- R10: A write strobe in the same cycle as the end strobe is judged with the latch value held before that edge, and every byte of a multi-byte memory write in one transaction sees the same latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start_i | input | 1 | One-cycle strobe: chip-select falling edge |
| cs_end_i | input | 1 | One-cycle strobe: chip-select rising edge |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| en_set_i | input | 1 | Set-enable command strobe |
| en_clr_i | input | 1 | Clear-enable command strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 8 | Status write data byte |
| mem_wr_i | input | 1 | Memory byte write strobe |
| mem_addr_i | input | ADDR_W | Byte address of the memory write |
| status_o | output | 8 | Readable status byte |
| sr_grant_o | output | 1 | Status write accepted this cycle |
| mem_grant_o | output | 1 | Memory byte write accepted this cycle |

## Verification
The write that closes a transaction and the end-of-transaction latch clear can fall in the same clock cycle. The bench provokes this by driving the last memory byte strobe, or the status write, together with the end strobe. A grant is then expected from the latch value before the edge, and status bit 1 must read 0 one cycle later. A second overlap is set-enable against clear-enable, driven together, where the latch must come out 0. A reference model in the bench judges every cycle from the requirements alone and compares both grants and the status byte.

// File: rtl/nvstat_pkg.sv
package nvstat_pkg;

  localparam int STAT_W = 8;

  // Bit positions of the status byte that neighbours decode.
  localparam int POS_ARM = 7;
  localparam int POS_ONE = 6;
  localparam int POS_BPH = 3;
  localparam int POS_BPL = 2;
  localparam int POS_WEL = 1;

  // Nonvolatile protection state.
  typedef struct packed {
    logic       arm;
    logic [1:0] rng;
  } nv_t;

  localparam int NV_W = $bits(nv_t);

  // Protected-range decision from the range field and the two address MSBs.
  function automatic logic range_hit(input logic [1:0] rng, input logic [1:0] top2);
    logic hit;
    unique case (rng)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/nvstat_wel.sv
module nvstat_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_start_i,
  input  logic cs_end_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic wr_seen_i,
  output logic wel_o
);

  logic wel_q, wel_d;
  logic wcls_q, wcls_d;
  logic end_clear;

  // A write-class transaction is one that carried any write strobe,
  // including one on the very cycle of the end strobe.
  assign end_clear = cs_end_i & (wcls_q | wr_seen_i);

  always_comb begin
    wcls_d = wcls_q;
    if (cs_start_i || cs_end_i) begin
      wcls_d = 1'b0;
    end else if (wr_seen_i) begin
      wcls_d = 1'b1;
    end
  end

  always_comb begin
    wel_d = wel_q;
    if (en_clr_i || end_clear) begin
      wel_d = 1'b0;
    end else if (en_set_i) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wcls_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      wcls_q <= wcls_d;
    end
  end

  assign wel_o = wel_q;

endmodule

// File: rtl/nvstat_lock.sv
module nvstat_lock
  import nvstat_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start_i,
  input  logic              wp_n_i,
  input  logic              sr_wr_i,
  input  logic [STAT_W-1:0] sr_wdata_i,
  input  logic              wel_i,
  output logic              grant_o,
  output nv_t               nv_o
);

  logic pin_q, pin_d;
  nv_t  nv_q, nv_d;
  logic locked;
  logic grant;

  // Pin captured at transaction start and held until the next start.
  always_comb begin
    pin_d = pin_q;
    if (cs_start_i) begin
      pin_d = wp_n_i;
    end
  end

  assign locked = nv_q.arm & ~pin_q;
  assign grant  = sr_wr_i & wel_i & ~locked;

  always_comb begin
    nv_d = nv_q;
    if (grant) begin
      nv_d.arm = sr_wdata_i[POS_ARM];
      nv_d.rng = {sr_wdata_i[POS_BPH], sr_wdata_i[POS_BPL]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      nv_q  <= nv_t'(NV_RST_VAL);
    end else begin
      pin_q <= pin_d;
      nv_q  <= nv_d;
    end
  end

  assign grant_o = grant;
  assign nv_o    = nv_q;

endmodule

// File: rtl/nvstat_range.sv
module nvstat_range
  import nvstat_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [1:0]        rng_i,
  input  logic              wel_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              grant_o
);

  localparam int TOP_HI = ADDR_W - 1;
  localparam int TOP_LO = ADDR_W - 2;

  logic [1:0] top2;
  logic       hit;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = mem_addr_i[TOP_HI:TOP_LO];
    end else begin : g_narrow
      assign top2 = {mem_addr_i[0], 1'b0};
    end
  endgenerate

  assign hit     = range_hit(rng_i, top2);
  assign grant_o = mem_wr_i & wel_i & ~hit;

endmodule

// File: rtl/nvstat_guard.sv
module nvstat_guard
  import nvstat_pkg::*;
#(
  parameter int               ADDR_W     = 18,
  parameter logic [NV_W-1:0]  NV_RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start_i,
  input  logic              cs_end_i,
  input  logic              wp_n_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic [7:0]        status_o,
  output logic              sr_grant_o,
  output logic              mem_grant_o
);

  logic wel;
  nv_t  nv;

  nvstat_wel u_wel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_start_i(cs_start_i),
    .cs_end_i  (cs_end_i),
    .en_set_i  (en_set_i),
    .en_clr_i  (en_clr_i),
    .wr_seen_i (sr_wr_i | mem_wr_i),
    .wel_o     (wel)
  );

  nvstat_lock #(
    .NV_RST_VAL(NV_RST_VAL)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_start_i(cs_start_i),
    .wp_n_i    (wp_n_i),
    .sr_wr_i   (sr_wr_i),
    .sr_wdata_i(sr_wdata_i),
    .wel_i     (wel),
    .grant_o   (sr_grant_o),
    .nv_o      (nv)
  );

  nvstat_range #(
    .ADDR_W(ADDR_W)
  ) u_range (
    .rng_i     (nv.rng),
    .wel_i     (wel),
    .mem_wr_i  (mem_wr_i),
    .mem_addr_i(mem_addr_i),
    .grant_o   (mem_grant_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[POS_ARM] = nv.arm;
    status_o[POS_ONE] = 1'b1;
    status_o[POS_BPH] = nv.rng[1];
    status_o[POS_BPL] = nv.rng[0];
    status_o[POS_WEL] = wel;
  end

endmodule

// File: rtl/nvstat_guard_chk.sv
module nvstat_guard_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_end_i,
  input logic              en_set_i,
  input logic              en_clr_i,
  input logic              sr_wr_i,
  input logic              mem_wr_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [7:0]        status_o,
  input logic              sr_grant_o,
  input logic              mem_grant_o
);

  assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] == 1'b1) && (status_o[5:4] == 2'b00) && (status_o[0] == 1'b0));

  assert_wel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(en_set_i));

  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_i |=> !status_o[1]);

  assert_end_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end_i && (sr_wr_i || mem_wr_i)) |=> !status_o[1]);

  assert_sr_grant_need_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |-> (sr_wr_i && status_o[1]));

  assert_sr_grant_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && status_o[1] && !status_o[7]) |-> sr_grant_o);

  assert_nv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_grant_o |=> ($stable(status_o[7]) && $stable(status_o[3:2])));

  assert_full_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !mem_grant_o);

  assert_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_i && status_o[1] && !mem_addr_i[ADDR_W-1] && (status_o[3:2] != 2'b11))
      |-> mem_grant_o);

  assert_mem_grant_need_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_o |-> (mem_wr_i && status_o[1]));

endmodule

bind nvstat_guard nvstat_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_end_i   (cs_end_i),
  .en_set_i   (en_set_i),
  .en_clr_i   (en_clr_i),
  .sr_wr_i    (sr_wr_i),
  .mem_wr_i   (mem_wr_i),
  .mem_addr_i (mem_addr_i),
  .status_o   (status_o),
  .sr_grant_o (sr_grant_o),
  .mem_grant_o(mem_grant_o)
);

// File: tb/nvstat_guard_tb.sv
`timescale 1ns/1ps
module nvstat_guard_tb;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_start, cs_end, wp_n, en_set, en_clr, sr_wr, mem_wr;
  logic [7:0]    wdata;
  logic [AW-1:0] addr;
  logic [7:0]    status;
  logic          sr_grant, mem_grant;

  int   n_checks = 0;
  int   n_fails  = 0;
  logic done     = 1'b0;

  // Reference model state.
  logic       m_wel, m_pin, m_wcls;
  logic [2:0] m_nv;   // [2] arm, [1:0] range

  always #2.5 clk = ~clk;

  nvstat_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_start_i(cs_start), .cs_end_i(cs_end),
    .wp_n_i(wp_n), .en_set_i(en_set), .en_clr_i(en_clr), .sr_wr_i(sr_wr),
    .sr_wdata_i(wdata), .mem_wr_i(mem_wr), .mem_addr_i(addr),
    .status_o(status), .sr_grant_o(sr_grant), .mem_grant_o(mem_grant)
  );

  function automatic logic prot(input logic [1:0] r, input logic [AW-1:0] a);
    case (r)
      2'd0:    return 1'b0;
      2'd1:    return a >= 18'h30000;
      2'd2:    return a >= 18'h20000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_nv[2], 1'b1, 2'b00, m_nv[1:0], m_wel, 1'b0};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs driven at the falling edge, grants judged before the
  // rising edge, status judged at the next falling edge.
  task automatic cyc(input logic s, input logic c, input logic sw, input logic [7:0] d,
                     input logic mw, input logic [AW-1:0] a, input logic f, input logic r,
                     input string tag);
    logic e_sr, e_mem, any_wr;
    en_set = s; en_clr = c; sr_wr = sw; wdata = d; mem_wr = mw; addr = a;
    cs_start = f; cs_end = r;
    #1;
    e_sr  = sw & m_wel & ~(m_nv[2] & ~m_pin);
    e_mem = mw & m_wel & ~prot(m_nv[1:0], a);
    chk(tag, "sr_grant",  {7'd0, sr_grant},  {7'd0, e_sr});
    chk(tag, "mem_grant", {7'd0, mem_grant}, {7'd0, e_mem});
    @(posedge clk);
    any_wr = sw | mw;
    if (e_sr) m_nv = {d[7], d[3], d[2]};
    if (c || (r && (m_wcls || any_wr))) m_wel = 1'b0;
    else if (s) m_wel = 1'b1;
    if (f || r) m_wcls = 1'b0;
    else if (any_wr) m_wcls = 1'b1;
    if (f) m_pin = wp_n;
    @(negedge clk);
    chk(tag, "status", status, exp_status());
    en_set = 0; en_clr = 0; sr_wr = 0; mem_wr = 0; cs_start = 0; cs_end = 0;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 0, '0, 0, 0, tag);
  endtask

  task automatic start(input logic pin, input string tag);
    wp_n = pin;
    cyc(0, 0, 0, 8'h00, 0, '0, 1, 0, tag);
  endtask

  task automatic finish_tr(input string tag);
    cyc(0, 0, 0, 8'h00, 0, '0, 0, 1, tag);
  endtask

  task automatic do_wren(input logic pin);
    start(pin, "R2");
    cyc(1, 0, 0, 8'h00, 0, '0, 0, 0, "R2");
    finish_tr("R2");
  endtask

  task automatic do_wrsr(input logic pin, input logic [7:0] d);
    start(pin, "R5");
    cyc(0, 0, 1, d, 0, '0, 0, 0, "R5");
    finish_tr("R4");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; wp_n = 1; cs_start = 0; cs_end = 0; en_set = 0; en_clr = 0;
    sr_wr = 0; mem_wr = 0; wdata = 0; addr = '0;
    m_wel = 0; m_pin = 0; m_wcls = 0; m_nv = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "reset status", status, 8'h40);

    // R5: status write without latch denied.
    do_wrsr(1, 8'h8C);
    // R2: status write with bit1 set cannot set latch.
    do_wren(1);
    do_wrsr(1, 8'hF3);          // accepted: arm=1, range=00; R1 fixed bits
    chk("R1", "fixed bits", status, 8'hC0);
    // R5: locked with arm=1 and pin low.
    do_wren(0);
    do_wrsr(0, 8'h0C);
    chk("R5", "locked write", status, 8'hC0);
    // R6: pin goes low mid-transaction, sampled high: accepted.
    do_wren(1);
    start(1, "R6");
    wp_n = 0;
    cyc(0, 0, 1, 8'h84, 0, '0, 0, 0, "R6");
    finish_tr("R6");
    chk("R6", "mid-transaction pin", status, 8'hC4);
    // R6: pin high mid-transaction, sampled low: locked.
    do_wren(0);
    start(0, "R6");
    wp_n = 1;
    cyc(0, 0, 1, 8'h00, 0, '0, 0, 0, "R6");
    finish_tr("R6");
    chk("R6", "sampled low", status, 8'hC4);

    // R7/R8: range 01 boundaries; pin low does not matter.
    do_wren(0);
    start(0, "R8");
    cyc(0, 0, 0, 0, 1, 18'h2FFFF, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 18'h30000, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 18'h3FFFF, 0, 1, "R10");   // last byte with end strobe
    chk("R4", "latch after write", status, 8'hC4);
    // Range 10 then 11 (arm cleared first with pin high).
    do_wren(1);
    do_wrsr(1, 8'h08);
    do_wren(1);
    start(1, "R7");
    cyc(0, 0, 0, 0, 1, 18'h1FFFF, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 18'h20000, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 18'h00000, 0, 0, "R10");
    finish_tr("R4");
    do_wren(1);
    do_wrsr(1, 8'h0C);
    do_wren(1);
    start(1, "R7");
    cyc(0, 0, 0, 0, 1, 18'h00000, 0, 0, "R7");
    finish_tr("R4");
    // R3: set and clear together; clear wins.
    start(1, "R3");
    cyc(1, 1, 0, 0, 0, '0, 0, 0, "R3");
    finish_tr("R3");
    chk("R3", "set+clear", status[1] ? 8'h1 : 8'h0, 8'h0);
    // R4: non-write transaction keeps latch.
    do_wren(1);
    start(1, "R4");
    idle("R4");
    finish_tr("R4");
    chk("R4", "read keeps latch", {7'd0, status[1]}, 8'h1);
    // R10: status write on the end cycle is granted, latch cleared after.
    start(1, "R10");
    cyc(0, 0, 1, 8'h00, 0, '0, 0, 1, "R10");
    chk("R10", "wrsr at end", status, 8'h40);

    // Random transactions.
    for (int i = 0; i < 400; i++) begin
      int kind;
      logic pin;
      kind = $urandom_range(0, 5);
      pin  = $urandom_range(0, 1);
      if ($urandom_range(0, 1) == 1) do_wren($urandom_range(0, 1));
      start(pin, "R5");
      case (kind)
        0: cyc(1, 0, 0, 0, 0, '0, 0, 0, "R2");
        1: cyc(0, 1, 0, 0, 0, '0, 0, 0, "R3");
        2: cyc(0, 0, 1, 8'($urandom), 0, '0, 0, 0, "R5");
        3: begin
          int nb;
          nb = $urandom_range(1, 4);
          for (int b = 0; b < nb; b++) cyc(0, 0, 0, 0, 1, AW'($urandom), 0, 0, "R8");
        end
        4: idle("R4");
        default: begin
          wp_n = ~pin;
          cyc(0, 0, 1, 8'($urandom), 0, '0, 0, 0, "R6");
        end
      endcase
      if ($urandom_range(0, 3) == 0)
        cyc(0, 0, 0, 0, 1, AW'($urandom), 0, 1, "R10");
      else
        finish_tr("R4");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule